// File: doc/BRIEF.md
# Two-Stage Pipeline Operand Bypass and Squash Control

This block is the control spine of a 32-bit integer core split into two pipeline stages. The first stage fetches an instruction and reads two source registers. The second stage executes the instruction, accesses data memory and writes the result back. The block owns the fetch program counter and the register that carries a decoded instruction from the first stage to the second. It also decides which value each source operand takes on its way into that register.

A dependent instruction never waits. When the instruction in the second stage is about to write the register that the first stage is reading, the block replaces the stale register-file data with the final writeback value. When the second stage resolves a taken branch or a jump, the block steers the program counter to the computed target on the next clock edge. In the same edge it squashes the one younger instruction, which enters the second stage as an invalid slot. An invalid slot cannot write a register, cannot store, and cannot redirect.

The ALU, the branch comparator, the decoder, the register file and the memories sit outside the block. The block sees only their results.

Top module: `pl2_pipe_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, `pc` loads the reset address (default 32'h0000_0200) and `ex_valid` clears to 0.
- R2: When no redirect fires in a cycle, `pc` advances by 4 at the next rising edge and `pc_sel` is 0.
- R3: If the second-stage slot is valid with its write enable at 1 and a destination other than 0, every source index equal to that destination takes `wb_data` instead of the register-file data.
- R4: If the second-stage slot is invalid, or its write enable is 0, each operand equals its register-file read data, even when the indices match.
- R5: A source index of 0 always gives an operand of 0, whatever the register-file data, `wb_data` or the second-stage destination.
- R6: A redirect fires when `redirect_req` is 1 and the second-stage slot is valid. In that cycle `pc_sel` is 1, and at the next rising edge `pc` loads `redirect_tgt`.
- R7: In the cycle a redirect fires, `squash` is 1. The first-stage instruction enters the second stage with `ex_valid` 0 and `ex_we` 0.
- R8: `redirect_req` has no effect while the second-stage slot is invalid: `pc_sel` stays 0 and `pc` advances by 4.
- R9: An instruction that is not squashed enters the second stage with its fetch address, instruction word, both bypassed operands, destination index and write enable, and with `ex_valid` at 1.
- R10: The two source ports choose their values independently. Both ports take `wb_data` when both indices match the second-stage destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| id_instr | input | 32 | Instruction word fetched at `pc` |
| id_rs1 | input | 5 | First source register index from the decoder |
| id_rs2 | input | 5 | Second source register index from the decoder |
| id_rd | input | 5 | Destination register index from the decoder |
| id_we | input | 1 | Decoded register write enable |
| rf_rdata1 | input | 32 | Register-file data for `id_rs1` |
| rf_rdata2 | input | 32 | Register-file data for `id_rs2` |
| wb_data | input | 32 | Final second-stage writeback value |
| redirect_req | input | 1 | Second stage resolved a taken branch or a jump |
| redirect_tgt | input | 32 | Target address computed in the second stage |
| pc | output | 32 | Current fetch address |
| pc_sel | output | 1 | 1 when the next address is the redirect target |
| squash | output | 1 | First-stage instruction is being discarded this cycle |
| id_opnd1 | output | 32 | Bypassed first operand |
| id_opnd2 | output | 32 | Bypassed second operand |
| ex_pc | output | 32 | Fetch address of the second-stage instruction |
| ex_instr | output | 32 | Second-stage instruction word |
| ex_opnd1 | output | 32 | Second-stage first operand |
| ex_opnd2 | output | 32 | Second-stage second operand |
| ex_rd | output | 5 | Second-stage destination index |
| ex_we | output | 1 | Second-stage register write enable, 0 when the slot is invalid |
| ex_valid | output | 1 | Second-stage slot holds a live instruction |

## Verification
The bench targets the cases where bypass qualification goes wrong:
- A write to register 0 must not leak `wb_data` into a read of register 0.
- A slot with its write enable low must not forward.
- A squashed slot that still carries a matching destination and a raised write enable must not forward. A design that qualifies only on index equality fails this case.

On the control side, the bench holds `redirect_req` high across the squashed cycle. A design that does not gate the redirect with slot validity would jump a second time. The bench also checks that the redirect target lands one edge later and not earlier. Finally, it checks that a non-squashed slot carries the bypassed operands and not the raw register-file data.

// File: rtl/pl2_pkg.sv
// Shared widths and the second-stage slot record.
// Assumes a 32-bit datapath and a 32-entry register file.
package pl2_pkg;
    localparam int XLEN    = 32;
    localparam int REG_CNT = 32;
    localparam int REG_AW  = $clog2(REG_CNT);

    typedef struct packed {
        logic [XLEN-1:0]   pc;
        logic [XLEN-1:0]   instr;
        logic [XLEN-1:0]   opnd1;
        logic [XLEN-1:0]   opnd2;
        logic [REG_AW-1:0] rd;
        logic              we;
        logic              valid;
    } ex_slot_t;
endpackage

// File: rtl/pl2_fwd_sel.sv
// Operand bypass for one read port.
// Assumes ex_live is already qualified by slot validity and write enable.
// Register index 0 reads as zero, with higher priority than the bypass.
module pl2_fwd_sel #(
    parameter int XLEN   = 32,
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] rs_idx,
    input  logic [XLEN-1:0]   rf_data,
    input  logic              ex_live,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic [XLEN-1:0]   wb_data,
    output logic [XLEN-1:0]   opnd
);
    localparam logic [REG_AW-1:0] ZERO_IDX = '0;

    logic hit;

    // match against the live second-stage destination
    always_comb begin
        hit = ex_live && (ex_rd != ZERO_IDX) && (ex_rd == rs_idx);
    end

    // choose zero, the writeback value or the register-file data
    always_comb begin
        if (rs_idx == ZERO_IDX)
            opnd = '0;
        else if (hit)
            opnd = wb_data;
        else
            opnd = rf_data;
    end
endmodule

// File: rtl/pl2_pc_seq.sv
// Fetch address register.
// Assumes redirect_fire is already gated by second-stage validity.
// Steps by PC_STEP, or loads the target on the edge after a redirect fires.
module pl2_pc_seq #(
    parameter int              XLEN       = 32,
    parameter logic [XLEN-1:0] RESET_ADDR = 32'h0000_0200,
    parameter int              PC_STEP    = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            redirect_fire,
    input  logic [XLEN-1:0] redirect_tgt,
    output logic [XLEN-1:0] pc,
    output logic            pc_sel
);
    localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

    logic [XLEN-1:0] pc_next;

    // next-address selection
    always_comb begin
        pc_sel  = redirect_fire;
        pc_next = redirect_fire ? redirect_tgt : pc + STEP;
    end

    // program counter register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= RESET_ADDR;
        else
            pc <= pc_next;
    end

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect_fire |=> pc == $past(pc) + STEP);                 // R2
    AST_PC_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_fire |=> pc == $past(redirect_tgt));               // R6
endmodule

// File: rtl/pl2_ex_slot.sv
// Stage-1 to stage-2 pipeline register.
// A flush clears the valid and write-enable bits of the captured slot.
// Reset clears the valid bit.
module pl2_ex_slot
    import pl2_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     flush,
    input  ex_slot_t d,
    output ex_slot_t q
);
    // capture the slot; flush or reset turns it into a bubble
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
        end else begin
            q       <= d;
            q.valid <= d.valid && !flush;
            q.we    <= d.we && !flush;
        end
    end

    AST_FLUSH_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !q.valid && !q.we);                               // R7
    AST_KEEP_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> q.valid && q.rd == $past(d.rd));                 // R9
endmodule

// File: rtl/pl2_pipe_ctrl.sv
// Top level of the two-stage bypass and squash control.
// Stage 1 presents decoded indices and register-file data.
// Stage 2 returns its writeback value and the redirect request.
// Dependent reads are bypassed, and a taken redirect squashes the one younger instruction.
module pl2_pipe_ctrl
    import pl2_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_ADDR = 32'h0000_0200,
    parameter int              PC_STEP    = 4,
    parameter int              RD_PORTS   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   id_instr,
    input  logic [REG_AW-1:0] id_rs1,
    input  logic [REG_AW-1:0] id_rs2,
    input  logic [REG_AW-1:0] id_rd,
    input  logic              id_we,
    input  logic [XLEN-1:0]   rf_rdata1,
    input  logic [XLEN-1:0]   rf_rdata2,
    input  logic [XLEN-1:0]   wb_data,
    input  logic              redirect_req,
    input  logic [XLEN-1:0]   redirect_tgt,
    output logic [XLEN-1:0]   pc,
    output logic              pc_sel,
    output logic              squash,
    output logic [XLEN-1:0]   id_opnd1,
    output logic [XLEN-1:0]   id_opnd2,
    output logic [XLEN-1:0]   ex_pc,
    output logic [XLEN-1:0]   ex_instr,
    output logic [XLEN-1:0]   ex_opnd1,
    output logic [XLEN-1:0]   ex_opnd2,
    output logic [REG_AW-1:0] ex_rd,
    output logic              ex_we,
    output logic              ex_valid
);
    ex_slot_t          slot_d;
    ex_slot_t          slot_q;
    logic              fire;
    logic              ex_live;
    logic [XLEN-1:0]   rs_data [RD_PORTS];
    logic [REG_AW-1:0] rs_idx  [RD_PORTS];
    logic [XLEN-1:0]   rs_out  [RD_PORTS];

    // redirect is only honoured from a live slot
    always_comb begin
        fire    = redirect_req && slot_q.valid;
        ex_live = slot_q.valid && slot_q.we;
        squash  = fire;
    end

    // gather the read ports into arrays
    always_comb begin
        rs_idx[0]  = id_rs1;
        rs_idx[1]  = id_rs2;
        rs_data[0] = rf_rdata1;
        rs_data[1] = rf_rdata2;
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_port
        pl2_fwd_sel #(.XLEN(XLEN), .REG_AW(REG_AW)) u_fwd (
            .rs_idx  (rs_idx[p]),
            .rf_data (rs_data[p]),
            .ex_live (ex_live),
            .ex_rd   (slot_q.rd),
            .wb_data (wb_data),
            .opnd    (rs_out[p])
        );
    end

    pl2_pc_seq #(.XLEN(XLEN), .RESET_ADDR(RESET_ADDR), .PC_STEP(PC_STEP)) u_pc (
        .clk           (clk),
        .rst_n         (rst_n),
        .redirect_fire (fire),
        .redirect_tgt  (redirect_tgt),
        .pc            (pc),
        .pc_sel        (pc_sel)
    );

    // assemble the slot presented to stage 2
    always_comb begin
        slot_d.pc    = pc;
        slot_d.instr = id_instr;
        slot_d.opnd1 = rs_out[0];
        slot_d.opnd2 = rs_out[1];
        slot_d.rd    = id_rd;
        slot_d.we    = id_we;
        slot_d.valid = 1'b1;
    end

    pl2_ex_slot u_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (fire),
        .d     (slot_d),
        .q     (slot_q)
    );

    // drive the outputs from the stage-2 slot and the bypass ports
    always_comb begin
        id_opnd1 = rs_out[0];
        id_opnd2 = rs_out[1];
        ex_pc    = slot_q.pc;
        ex_instr = slot_q.instr;
        ex_opnd1 = slot_q.opnd1;
        ex_opnd2 = slot_q.opnd2;
        ex_rd    = slot_q.rd;
        ex_we    = slot_q.we;
        ex_valid = slot_q.valid;
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> pc == RESET_ADDR && !ex_valid);                  // R1
    AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        id_rs1 == '0 |-> id_opnd1 == '0);                           // R5
    AST_NO_DEAD_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_valid |-> !pc_sel && !squash);                          // R8
    AST_DEAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_valid |-> !ex_we);                                      // R7
    AST_BYPASS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_we && ex_rd != '0 && id_rs2 == ex_rd)
        |-> id_opnd2 == wb_data);                                   // R3
endmodule

// File: tb/tb_pl2_pipe_ctrl.sv
module tb_pl2_pipe_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] id_instr, rf_rdata1, rf_rdata2, wb_data, redirect_tgt;
    logic [4:0]  id_rs1, id_rs2, id_rd;
    logic        id_we, redirect_req;
    logic [31:0] pc, id_opnd1, id_opnd2, ex_pc, ex_instr, ex_opnd1, ex_opnd2;
    logic [4:0]  ex_rd;
    logic        pc_sel, squash, ex_we, ex_valid;

    int total = 0;
    int bad   = 0;
    localparam logic [31:0] RST_PC = 32'h0000_0200;

    pl2_pipe_ctrl dut (
        .clk(clk), .rst_n(rst_n), .id_instr(id_instr), .id_rs1(id_rs1),
        .id_rs2(id_rs2), .id_rd(id_rd), .id_we(id_we), .rf_rdata1(rf_rdata1),
        .rf_rdata2(rf_rdata2), .wb_data(wb_data), .redirect_req(redirect_req),
        .redirect_tgt(redirect_tgt), .pc(pc), .pc_sel(pc_sel), .squash(squash),
        .id_opnd1(id_opnd1), .id_opnd2(id_opnd2), .ex_pc(ex_pc),
        .ex_instr(ex_instr), .ex_opnd1(ex_opnd1), .ex_opnd2(ex_opnd2),
        .ex_rd(ex_rd), .ex_we(ex_we), .ex_valid(ex_valid)
    );

    always #10 clk = ~clk;  // 50 MHz

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // advance one edge; inputs change 1 ns after it
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        id_instr = 32'h0000_0013; id_rs1 = 5'd0; id_rs2 = 5'd0;
        id_rd = 5'd0; id_we = 1'b0; rf_rdata1 = '0; rf_rdata2 = '0;
        wb_data = '0; redirect_req = 1'b0; redirect_tgt = '0;
    endtask

    // place a live instruction with the given destination into stage 2
    task automatic load_slot(input logic [4:0] rd, input logic we);
        idle_inputs();
        id_rd = rd; id_we = we;
        step();
    endtask

    task automatic t_reset();
        idle_inputs();
        rst_n = 1'b0;
        step(); step();
        chk("R1", "pc", pc, RST_PC);
        chk("R1", "ex_valid", {31'b0, ex_valid}, 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_sequential();
        logic [31:0] p0;
        idle_inputs();
        #1;
        p0 = pc;
        chk("R2", "pc_sel", {31'b0, pc_sel}, 32'd0);
        step();
        chk("R2", "pc+4", pc, p0 + 32'd4);
    endtask

    task automatic t_bypass();
        load_slot(5'd5, 1'b1);
        id_rs1 = 5'd5; id_rs2 = 5'd7;
        rf_rdata1 = 32'h1111_1111; rf_rdata2 = 32'h2222_2222;
        wb_data = 32'hCAFE_0005;
        #1;
        chk("R3", "opnd1 bypassed", id_opnd1, 32'hCAFE_0005);
        chk("R10", "opnd2 independent", id_opnd2, 32'h2222_2222);
        id_rs2 = 5'd5;
        #1;
        chk("R10", "both ports opnd1", id_opnd1, 32'hCAFE_0005);
        chk("R10", "both ports opnd2", id_opnd2, 32'hCAFE_0005);
    endtask

    task automatic t_no_we();
        load_slot(5'd5, 1'b0);
        id_rs1 = 5'd5; rf_rdata1 = 32'h3333_3333; wb_data = 32'hBAD0_BAD0;
        #1;
        chk("R4", "we low no bypass", id_opnd1, 32'h3333_3333);
    endtask

    task automatic t_zero();
        load_slot(5'd0, 1'b1);
        id_rs1 = 5'd0; rf_rdata1 = 32'h4444_4444; wb_data = 32'h5555_5555;
        #1;
        chk("R5", "x0 with rd 0", id_opnd1, 32'd0);
        load_slot(5'd6, 1'b1);
        id_rs2 = 5'd0; rf_rdata2 = 32'h6666_6666; wb_data = 32'h7777_7777;
        #1;
        chk("R5", "x0 port2", id_opnd2, 32'd0);
    endtask

    task automatic t_redirect();
        logic [31:0] p_before;
        load_slot(5'd9, 1'b1);
        id_rd = 5'd8; id_we = 1'b1;
        redirect_req = 1'b1; redirect_tgt = 32'h0000_0400;
        #1;
        chk("R6", "pc_sel", {31'b0, pc_sel}, 32'd1);
        chk("R7", "squash", {31'b0, squash}, 32'd1);
        step();
        chk("R6", "pc target", pc, 32'h0000_0400);
        chk("R7", "ex_valid", {31'b0, ex_valid}, 32'd0);
        chk("R7", "ex_we", {31'b0, ex_we}, 32'd0);
        // dead slot still carries rd 8: no bypass, no second redirect
        id_rs1 = 5'd8; rf_rdata1 = 32'h8888_8888; wb_data = 32'h9999_9999;
        redirect_req = 1'b1; redirect_tgt = 32'h0000_0800;
        #1;
        chk("R4", "dead slot no bypass", id_opnd1, 32'h8888_8888);
        chk("R8", "pc_sel dead", {31'b0, pc_sel}, 32'd0);
        p_before = pc;
        step();
        chk("R8", "pc steps", pc, p_before + 32'd4);
        redirect_req = 1'b0;
    endtask

    task automatic t_capture();
        logic [31:0] p0;
        load_slot(5'd3, 1'b1);
        id_instr = 32'hDEAD_BEEF; id_rd = 5'd12; id_we = 1'b1;
        id_rs1 = 5'd3; id_rs2 = 5'd4;
        rf_rdata1 = 32'h0A0A_0A0A; rf_rdata2 = 32'h0B0B_0B0B;
        wb_data = 32'h0C0C_0C0C;
        #1;
        p0 = pc;
        step();
        chk("R9", "ex_pc", ex_pc, p0);
        chk("R9", "ex_instr", ex_instr, 32'hDEAD_BEEF);
        chk("R9", "ex_opnd1 bypassed", ex_opnd1, 32'h0C0C_0C0C);
        chk("R9", "ex_opnd2", ex_opnd2, 32'h0B0B_0B0B);
        chk("R9", "ex_rd", {27'b0, ex_rd}, 32'd12);
        chk("R9", "ex_we", {31'b0, ex_we}, 32'd1);
        chk("R9", "ex_valid", {31'b0, ex_valid}, 32'd1);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        idle_inputs();
        t_reset();
        t_sequential();
        t_bypass();
        t_no_we();
        t_zero();
        t_redirect();
        t_capture();
        t_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule